// File: doc/BRIEF.md
# Voltage Code Reference Stepper

This block computes the digital code that feeds a regulator's reference DAC. The base code comes from one of two places: the code present on the external VID pins, or a code loaded through a small register write port. A signed calibration offset is added to the base code, and the sum is clamped to the code range.

The DAC code output does not jump to a new target. It walks one code at a time, and the walk is paced by an external tick input and a programmable rate, so that large target changes cannot draw an inrush current.

The target may change in one step or in several steps, in either direction, while the output is still moving. The output then turns toward the newest target from wherever it currently stands.

Top module: `vcode_stepper`

## Requirements
- R1: On reset, all internal registers clear to zero. The DAC code output is 0, the pins are the selected source, the offset is zero and the rate code is 0.
- R2: When the pins are selected, the target equals the pin code plus the offset.
- R3: A write to address 0x21 loads the register code. A write of bit 3 set to address 0xD2 or 0xD3 selects the register code only if 0x21 has been written at some time since reset. A write of bit 3 set that happens before any 0x21 write is stored as 0.
- R4: The register code is selected while bit 3 of either 0xD2 or 0xD3 is held set. Clearing both bits returns the target to the pin code.
- R5: Bits 5:0 of address 0xDD hold the offset. Bit 5 is the sign (0 adds, 1 subtracts) and bits 4:0 are the magnitude. One offset LSB equals one code, and a magnitude of zero with either sign adds nothing.
- R6: The base-plus-offset sum saturates at 0 and at 2^CODE_W-1.
- R7: Each output move changes the code by exactly one, in the direction of the target. Bits 2:0 of address 0xD6 hold a rate code n, and while the output differs from the target it moves once every n+1 ticks.
- R8: Without a tick the output holds its value. Once the output equals the target it stays there.
- R9: A target change during a ramp continues the ramp from the present output toward the new target, without any jump.
- R10: Writes to any address other than 0x21, 0xD2, 0xD3, 0xD6 and 0xDD change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_code | input | CODE_W | Code from the VID pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| tick | input | 1 | Slew timing tick |
| dac_code | output | CODE_W | Stepped code to the DAC |

## Verification
A corrupted tick counter or rate register shows up as a ramp that takes the wrong number of cycles per code. With ticks every cycle, this is visible within n+1 cycles of any target change. A wrong source-select bit or a wrong offset register sends the output toward a different final code. That error is seen once the ramp settles, which takes at most 2^CODE_W moves. A broken step rule shows on the first move, as a change of more than one code or a move away from the target.

// File: rtl/vcode_stepper.sv
module vcode_stepper #(
  parameter int CODE_W = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] A_CMD  = 'h21,
  parameter logic [ADDR_W-1:0] A_SELA = 'hD2,
  parameter logic [ADDR_W-1:0] A_SELB = 'hD3,
  parameter logic [ADDR_W-1:0] A_RATE = 'hD6,
  parameter logic [ADDR_W-1:0] A_OFS  = 'hDD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] pin_code,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  output logic [CODE_W-1:0] dac_code
);
  localparam int SW = CODE_W + 2;
  localparam logic signed [SW-1:0] MAXV = SW'((1 << CODE_W) - 1);

  logic [CODE_W-1:0] cmd_q, target;
  logic              cmd_seen, sel_a, sel_b;
  logic [5:0]        ofs_q;
  logic [2:0]        rate_q, cnt_q;
  logic signed [SW-1:0] base_s, mag_s, sum_s;

  assign base_s = $signed({2'b00, (sel_a | sel_b) ? cmd_q : pin_code});
  assign mag_s  = $signed({{(SW-5){1'b0}}, ofs_q[4:0]});
  assign sum_s  = ofs_q[5] ? base_s - mag_s : base_s + mag_s;

  always_comb begin
    if (sum_s < 0)          target = '0;
    else if (sum_s > MAXV)  target = '1;
    else                    target = sum_s[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      cmd_seen <= 1'b0;
      sel_a    <= 1'b0;
      sel_b    <= 1'b0;
      ofs_q    <= '0;
      rate_q   <= '0;
      cnt_q    <= '0;
      dac_code <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_CMD:  begin cmd_q <= wr_data[CODE_W-1:0]; cmd_seen <= 1'b1; end
          A_SELA: sel_a  <= wr_data[3] & cmd_seen;
          A_SELB: sel_b  <= wr_data[3] & cmd_seen;
          A_RATE: rate_q <= wr_data[2:0];
          A_OFS:  ofs_q  <= wr_data[5:0];
          default: ;
        endcase
      end
      if (tick) begin
        if (dac_code == target) begin
          cnt_q <= '0;
        end else if (cnt_q >= rate_q) begin
          cnt_q    <= '0;
          dac_code <= (dac_code < target) ? dac_code + 1'b1 : dac_code - 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

module vcode_stepper_chk #(parameter int W = 8) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [W-1:0] dac_code,
  input logic [W-1:0] target
);
  // R7
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |->
      (dac_code == W'($past(dac_code) + 1'b1) || dac_code == W'($past(dac_code) - 1'b1)));
  // R7
  toward_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |->
      ((dac_code > $past(dac_code)) == ($past(target) > $past(dac_code))));
  // R8
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(dac_code));
  // R8
  settled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code == target) |=> $stable(dac_code));
endmodule

bind vcode_stepper vcode_stepper_chk #(.W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .dac_code(dac_code), .target(target)
);

// File: tb/vcode_stepper_tb.sv
module vcode_stepper_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_code = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick = 1'b0;
  logic [7:0] dac_code;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vcode_stepper u_dut (
    .clk(clk), .rst_n(rst_n), .pin_code(pin_code), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .tick(tick), .dac_code(dac_code)
  );

  // {pin, offset register, expected settled code}
  localparam logic [23:0] VEC [8] = '{
    {8'd100, 8'h00, 8'd100},
    {8'd100, 8'h05, 8'd105},
    {8'd100, 8'h25, 8'd95},
    {8'd250, 8'h0A, 8'd255},
    {8'd3,   8'h24, 8'd0},
    {8'd0,   8'h1F, 8'd31},
    {8'd255, 8'h3F, 8'd224},
    {8'd128, 8'h20, 8'd128}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  initial begin
    run(3);
    chk("R1 reset output", dac_code, 0);
    rst_n = 1'b1;
    tick = 1'b1;
    run(5);
    chk("R1 pins selected zero offset", dac_code, 0);

    for (int i = 0; i < 8; i++) begin
      wr(8'hDD, VEC[i][15:8]);
      pin_code = VEC[i][23:16];
      run(300);
      chk($sformatf("R2/R5/R6 vector %0d", i), dac_code, VEC[i][7:0]);
    end
    wr(8'hDD, 8'h00);
    run(5);

    tick = 1'b0;
    pin_code = 8'd140;
    run(20);
    chk("R8 hold without tick", dac_code, 128);
    tick = 1'b1;
    run(1);
    chk("R8 moves on tick", dac_code, 129);
    run(20);
    chk("R8 settled", dac_code, 140);

    wr(8'hD6, 8'h03);
    pin_code = 8'd142;
    run(3);
    chk("R7 rate 3 before fourth tick", dac_code, 140);
    run(1);
    chk("R7 rate 3 first move", dac_code, 141);
    run(3);
    chk("R7 rate 3 between moves", dac_code, 141);
    run(1);
    chk("R7 rate 3 second move", dac_code, 142);
    wr(8'hD6, 8'h00);

    pin_code = 8'd10;
    run(200);
    pin_code = 8'd100;
    run(5);
    chk("R9 ramp up progress", dac_code, 15);
    pin_code = 8'd0;
    run(1);
    chk("R9 reversal without jump", dac_code, 14);
    run(20);
    chk("R9 new target reached", dac_code, 0);

    pin_code = 8'd20;
    run(40);
    wr(8'hD2, 8'h08);
    run(60);
    chk("R3 enable before code ignored", dac_code, 20);
    wr(8'h21, 8'd60);
    run(60);
    chk("R3 code alone does not select", dac_code, 20);
    wr(8'hD2, 8'h08);
    run(60);
    chk("R3 code then enable selects", dac_code, 60);
    wr(8'hD2, 8'h00);
    run(60);
    chk("R4 clear returns to pins", dac_code, 20);
    wr(8'hD3, 8'h08);
    run(60);
    chk("R4 second config selects", dac_code, 60);

    wr(8'h22, 8'hFF);
    wr(8'h20, 8'h08);
    wr(8'hD4, 8'h00);
    wr(8'hDC, 8'h1F);
    wr(8'hD7, 8'h07);
    run(60);
    chk("R10 other addresses ignored", dac_code, 60);
    wr(8'hD3, 8'h00);
    run(60);
    chk("R10 offset still zero", dac_code, 20);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    run(100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule